// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads two entries from a page table held in memory. A requester presents a virtual address and an access kind: read, write or execute. The walker then looks up a first-level directory entry. That entry points to a second-level table, and the walker reads the leaf entry from it. The result is either a physical address or a fault code that names the reason for the failure.

The top-level table's location comes from a root register that can be loaded from outside at any time. A walk uses the root value captured when its request is accepted. Memory is reached through one request port with a single outstanding transaction. Reads come back on a response channel. The walker uses the same port to write a leaf entry back with its modified flag set, when a permitted write touches a page that is not yet marked.

Top module: `pt_walker`

## Requirements
- R1: The directory entry is read at root + va[31:22]*4. The leaf entry is read at {dir[31:12], 12'h000} + va[21:12]*4. The leaf is read only after the directory entry has returned, and every read uses mem_req_write=0.
- R2: A successful walk returns resp_fault=0 and resp_paddr = {leaf[31:12], va[11:0]}.
- R3: A directory entry with bit 0 (valid) clear ends the walk with resp_fault=1 and resp_paddr=0, after exactly one memory read. This includes a null address whose directory slot is empty.
- R4: A leaf entry with bit 0 clear ends the walk with resp_fault=2 and resp_paddr=0, after two reads.
- R5: Each access kind needs one leaf flag. Kind 0 (read) needs bit 1, kind 1 (write) needs bit 2, and kind 2 (execute) needs bit 3. Kind 3 is never permitted. A missing permission gives resp_fault=3 and resp_paddr=0.
- R6: A permitted write to a leaf whose bit 4 (dirty) is clear writes the whole leaf back to its own address with bit 4 set, before the response appears. Reads, executes and writes to an already-dirty leaf write nothing.
- R7: The valid checks take priority over the permission check, and any fault suppresses the dirty write-back.
- R8: req_ready is high only when no walk is in progress, and mem_req_valid is never high together with it. A response is held unchanged until resp_ready accepts it.
- R9: The root register resets to 0 and takes base_value on a cycle with base_load high. Loading it during a walk does not affect that walk.
- R10: After reset, req_ready=1, resp_valid=0 and mem_req_valid=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_load | input | 1 | Load the root register this cycle |
| base_value | input | 32 | New root (directory) address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| resp_valid | output | 1 | Result present |
| resp_ready | input | 1 | Result consumed |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_fault | output | 2 | 0 none, 1 directory invalid, 2 leaf invalid, 3 permission |
| mem_req_valid | output | 1 | Memory transaction present |
| mem_req_ready | input | 1 | Memory accepts the transaction |
| mem_req_write | output | 1 | 1 for the dirty write-back, 0 for a read |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Leaf value written back |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Entry read from memory |

## Verification
The assertions assume that mem_rsp_valid is raised only while an accepted read is outstanding, and only once per read. They also assume that memory holds no request stalled forever. The bench's memory model answers each accepted read exactly once, one cycle later, and never sends an unsolicited response. It throttles mem_req_ready and resp_ready with fixed patterns, so that the hold properties are exercised. Root loads are either made between walks or deliberately made during one.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes 32-bit entries with the flags in bits 4:0.
package ptw_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_DIR  = 2'd1,
        FLT_LEAF = 2'd2,
        FLT_PERM = 2'd3
    } fault_t;

    localparam int FLAG_V = 0;
    localparam int FLAG_R = 1;
    localparam int FLAG_W = 2;
    localparam int FLAG_X = 3;
    localparam int FLAG_D = 4;
    localparam int FLAG_BITS = 5;
endpackage

// File: rtl/ptw_root_reg.sv
// Root register: holds the directory base address.
// Assumes the load is synchronous. It resets to zero.
module ptw_root_reg #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] value,
    output logic [ADDR_W-1:0] root
);
    // Capture a new root whenever load is asserted.
    always_ff @(posedge clk) begin
        if (!rst_n)
            root <= '0;
        else if (load)
            root <= value;
    end
endmodule

// File: rtl/ptw_addr_gen.sv
// Entry address generator: selects the level base and adds the scaled index.
// Assumes the entries are 4 bytes and the tables are page aligned.
module ptw_addr_gen #(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 10
) (
    input  logic                        leaf_level,
    input  logic [ADDR_W-1:0]           root,
    input  logic [ADDR_W-PAGE_BITS-1:0] tbl_ppn,
    input  logic [ADDR_W-1:0]           vaddr,
    output logic [ADDR_W-1:0]           entry_addr
);
    localparam int ENTRY_SHIFT = 2;
    localparam int DIR_W       = ADDR_W - PAGE_BITS - IDX_W;

    logic [ADDR_W-1:0] dir_off;
    logic [ADDR_W-1:0] leaf_off;
    logic [ADDR_W-1:0] leaf_base;

    // Scale the two index fields into byte offsets.
    always_comb begin
        dir_off  = {{(ADDR_W-DIR_W-ENTRY_SHIFT){1'b0}},
                    vaddr[ADDR_W-1 -: DIR_W], {ENTRY_SHIFT{1'b0}}};
        leaf_off = {{(ADDR_W-IDX_W-ENTRY_SHIFT){1'b0}},
                    vaddr[PAGE_BITS+IDX_W-1 -: IDX_W], {ENTRY_SHIFT{1'b0}}};
        leaf_base = {tbl_ppn, {PAGE_BITS{1'b0}}};
    end

    // Choose the level and form the entry address.
    always_comb begin
        entry_addr = leaf_level ? (leaf_base + leaf_off) : (root + dir_off);
    end
endmodule

// File: rtl/ptw_entry_check.sv
// Entry checker: decodes the valid and permission flags of a returned entry.
// Assumes the flags sit at the positions given in ptw_pkg. The valid check wins
// over the permission check.
module ptw_entry_check
    import ptw_pkg::*;
(
    input  logic [FLAG_BITS-1:0] flags,
    input  logic                 leaf_level,
    input  acc_kind_t            kind,
    output fault_t               fault,
    output logic                 need_dirty
);
    logic allowed;

    // Pick the permission flag that the access kind needs.
    always_comb begin
        case (kind)
            ACC_READ:  allowed = flags[FLAG_R];
            ACC_WRITE: allowed = flags[FLAG_W];
            ACC_EXEC:  allowed = flags[FLAG_X];
            default:   allowed = 1'b0;
        endcase
    end

    // Rank the faults and flag a needed dirty update.
    always_comb begin
        fault      = FLT_NONE;
        need_dirty = 1'b0;
        if (!flags[FLAG_V])
            fault = leaf_level ? FLT_LEAF : FLT_DIR;
        else if (leaf_level && !allowed)
            fault = FLT_PERM;
        else if (leaf_level && kind == ACC_WRITE && !flags[FLAG_D])
            need_dirty = 1'b1;
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker top.
// It accepts one request at a time and reads the directory entry, then the
// leaf entry. It checks the flags and may write the leaf back with its dirty
// bit set. The result is held until it is consumed. Assumes that memory gives
// exactly one response per accepted read.
module pt_walker
    import ptw_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int IDX_W     = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_load,
    input  logic [ADDR_W-1:0] base_value,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_kind,
    output logic              resp_valid,
    input  logic              resp_ready,
    output logic [ADDR_W-1:0] resp_paddr,
    output logic [1:0]        resp_fault,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [ADDR_W-1:0] mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data
);
    localparam int PPN_W = ADDR_W - PAGE_BITS;

    typedef enum logic [2:0] {
        S_IDLE, S_DIR_REQ, S_DIR_WAIT, S_LEAF_REQ, S_LEAF_WAIT, S_WB_REQ, S_DONE
    } state_t;

    state_t            state;
    logic [ADDR_W-1:0] va_q;
    acc_kind_t         kind_q;
    logic [ADDR_W-1:0] root_q;
    logic [PPN_W-1:0]  tppn_q;
    logic [ADDR_W-1:0] leaf_q;
    logic [ADDR_W-1:0] paddr_q;
    fault_t            fault_q;
    logic [ADDR_W-1:0] root_cur;
    logic [ADDR_W-1:0] entry_addr;
    logic              leaf_sel;
    logic              chk_leaf;
    fault_t            chk_fault;
    logic              chk_dirty;

    ptw_root_reg #(.ADDR_W(ADDR_W)) u_root (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (base_load),
        .value (base_value),
        .root  (root_cur)
    );

    // The leaf level is addressed in the leaf request and write-back states.
    always_comb begin
        leaf_sel = (state == S_LEAF_REQ) || (state == S_WB_REQ);
        chk_leaf = (state == S_LEAF_WAIT);
    end

    ptw_addr_gen #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) u_addr (
        .leaf_level (leaf_sel),
        .root       (root_q),
        .tbl_ppn    (tppn_q),
        .vaddr      (va_q),
        .entry_addr (entry_addr)
    );

    ptw_entry_check u_chk (
        .flags      (mem_rsp_data[FLAG_BITS-1:0]),
        .leaf_level (chk_leaf),
        .kind       (kind_q),
        .fault      (chk_fault),
        .need_dirty (chk_dirty)
    );

    // Walk sequencer: steps through the lookups and records the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            va_q    <= '0;
            kind_q  <= ACC_READ;
            root_q  <= '0;
            tppn_q  <= '0;
            leaf_q  <= '0;
            paddr_q <= '0;
            fault_q <= FLT_NONE;
        end else begin
            case (state)
                S_IDLE: if (req_valid) begin
                    va_q   <= req_vaddr;
                    kind_q <= acc_kind_t'(req_kind);
                    root_q <= root_cur;
                    state  <= S_DIR_REQ;
                end
                S_DIR_REQ: if (mem_req_ready) state <= S_DIR_WAIT;
                S_DIR_WAIT: if (mem_rsp_valid) begin
                    if (chk_fault != FLT_NONE) begin
                        fault_q <= chk_fault;
                        paddr_q <= '0;
                        state   <= S_DONE;
                    end else begin
                        tppn_q <= mem_rsp_data[ADDR_W-1:PAGE_BITS];
                        state  <= S_LEAF_REQ;
                    end
                end
                S_LEAF_REQ: if (mem_req_ready) state <= S_LEAF_WAIT;
                S_LEAF_WAIT: if (mem_rsp_valid) begin
                    if (chk_fault != FLT_NONE) begin
                        fault_q <= chk_fault;
                        paddr_q <= '0;
                        state   <= S_DONE;
                    end else begin
                        fault_q <= FLT_NONE;
                        paddr_q <= {mem_rsp_data[ADDR_W-1:PAGE_BITS], va_q[PAGE_BITS-1:0]};
                        leaf_q  <= mem_rsp_data | (ADDR_W'(1) << FLAG_D);
                        state   <= chk_dirty ? S_WB_REQ : S_DONE;
                    end
                end
                S_WB_REQ: if (mem_req_ready) state <= S_DONE;
                S_DONE: if (resp_ready) state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Drive the port outputs from the state and the held registers.
    always_comb begin
        req_ready     = (state == S_IDLE);
        resp_valid    = (state == S_DONE);
        resp_paddr    = paddr_q;
        resp_fault    = fault_q;
        mem_req_valid = (state == S_DIR_REQ) || (state == S_LEAF_REQ) || (state == S_WB_REQ);
        mem_req_write = (state == S_WB_REQ);
        mem_req_addr  = entry_addr;
        mem_req_wdata = leaf_q;
    end

    // R8: a pending result stays unchanged until it is taken.
    a_r8_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && !resp_ready |=> resp_valid && $stable(resp_paddr) && $stable(resp_fault));

    // R8: there is no memory traffic while a new request can be accepted.
    a_r8_single_walk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    // R1: a stalled memory request keeps its address and direction.
    a_r1_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_write));

    // R5: a faulting result carries a zero address.
    a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_fault != 2'd0 |-> resp_paddr == '0);

    // R6: the write-back carries a valid, dirty entry.
    a_r6_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write |-> mem_req_wdata[FLAG_D] && mem_req_wdata[FLAG_V]);

    // R7: a write-back is only followed by a fault-free result.
    a_r7_wb_no_fault: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_write && mem_req_ready |=> resp_valid && resp_fault == 2'd0);
endmodule

// File: tb/pt_walker_test.sv
// Scoreboard bench for pt_walker: the driver queues expected results and the
// monitor compares them with each accepted response.
module pt_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_load = 1'b0;
    logic [31:0] base_value = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        resp_valid;
    logic        resp_ready = 1'b0;
    logic [31:0] resp_paddr;
    logic [1:0]  resp_fault;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic [31:0] mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    always #10 clk = ~clk;

    pt_walker uut (
        .clk(clk), .rst_n(rst_n), .base_load(base_load), .base_value(base_value),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .resp_valid(resp_valid), .resp_ready(resp_ready),
        .resp_paddr(resp_paddr), .resp_fault(resp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data)
    );

    typedef struct {
        logic [31:0] paddr;
        logic [1:0]  fault;
        int          reads;
        int          writes;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] mem [bit [31:0]];
    logic [31:0] base_model = '0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic        hold_pend = 1'b0;
    logic [31:0] hold_paddr = '0;
    logic [1:0]  hold_fault = '0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference walk written from the requirements.
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind, input string tag);
        exp_t e;
        logic [31:0] d, t;
        logic ok;
        e.tag = tag; e.paddr = 0; e.writes = 0;
        d = rd(base_model + {20'h0, va[31:22], 2'b00});
        if (!d[0]) begin e.fault = 2'd1; e.reads = 1; return e; end
        e.reads = 2;
        t = rd({d[31:12], 12'h000} + {20'h0, va[21:12], 2'b00});
        if (!t[0]) begin e.fault = 2'd2; return e; end
        case (kind)
            2'd0: ok = t[1];
            2'd1: ok = t[2];
            2'd2: ok = t[3];
            default: ok = 1'b0;
        endcase
        if (!ok) begin e.fault = 2'd3; return e; end
        e.fault = 2'd0;
        e.paddr = {t[31:12], va[11:0]};
        e.writes = (kind == 2'd1 && !t[4]) ? 1 : 0;
        return e;
    endfunction

    // Memory model with throttled ready and responses after one cycle.
    always @(posedge clk) begin
        cyc++;
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                mem[mem_req_addr] = mem_req_wdata;
                wr_cnt++;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_data  <= rd(mem_req_addr);
                rd_cnt++;
            end
        end
        mem_req_ready <= (cyc % 3) != 2;
        resp_ready    <= (cyc % 5) != 3;
    end

    // Monitor: check the hold behaviour and compare the results with the scoreboard.
    always @(negedge clk) begin
        if (rst_n) begin
            if (hold_pend) begin
                check("R8 held paddr", resp_paddr, hold_paddr);
                check("R8 held fault", {30'h0, resp_fault}, {30'h0, hold_fault});
            end
            if (resp_valid) check("R8 busy ready", {31'h0, req_ready}, 32'h0);
            hold_pend  = resp_valid && !resp_ready;
            hold_paddr = resp_paddr;
            hold_fault = resp_fault;
            if (resp_valid && resp_ready) begin
                if (sb.size() == 0) begin
                    check("R8 unexpected response", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check({e.tag, " paddr"}, resp_paddr, e.paddr);
                    check({e.tag, " fault"}, {30'h0, resp_fault}, {30'h0, e.fault});
                    check({e.tag, " reads"}, rd_cnt, e.reads);
                    check({e.tag, " writes"}, wr_cnt, e.writes);
                end
                rd_cnt = 0;
                wr_cnt = 0;
            end
        end
    end

    task automatic issue(input logic [31:0] va, input logic [1:0] kind, input string tag);
        sb.push_back(model(va, kind, tag));
        @(negedge clk);
        req_vaddr = va; req_kind = kind; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic load_root(input logic [31:0] v);
        @(negedge clk);
        base_load = 1'b1; base_value = v;
        @(negedge clk);
        base_load = 1'b0;
    endtask

    initial begin
        // Page tables for the root at 0, at 0x10000 and at 0x50000.
        mem[32'h0000_0000] = 32'h0007_0001;
        mem[32'h0007_0000] = 32'h7777_7003;
        mem[32'h0001_0410] = 32'h0002_0001;
        mem[32'h0002_08EC] = 32'hC20A_3007;
        mem[32'h0001_0004] = 32'h0003_0001;
        mem[32'h0003_0000] = 32'h1234_500E;
        mem[32'h0003_0004] = 32'h5555_5009;
        mem[32'h0005_0410] = 32'h0006_0001;
        mem[32'h0006_08EC] = 32'hABCD_E003;
        repeat (3) @(negedge clk);
        check("R10 req_ready", {31'h0, req_ready}, 32'h1);
        check("R10 resp_valid", {31'h0, resp_valid}, 32'h0);
        check("R10 mem_req_valid", {31'h0, mem_req_valid}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after reset", {31'h0, req_ready}, 32'h1);

        issue(32'h0000_0538, 2'd0, "R9 reset root");
        drain();
        load_root(32'h0001_0000);
        base_model = 32'h0001_0000;
        issue(32'h4123_B538, 2'd0, "R2 read");
        issue(32'h0040_1FFC, 2'd2, "R5 exec");
        drain();
        issue(32'h4123_B538, 2'd1, "R6 first write");
        drain();
        check("R6 dirty set", mem[32'h0002_08EC], 32'hC20A_3017);
        issue(32'h4123_B538, 2'd1, "R6 second write");
        issue(32'h4123_B538, 2'd2, "R5 no exec");
        issue(32'h4123_B538, 2'd3, "R5 reserved kind");
        issue(32'h0000_0123, 2'd0, "R3 null");
        issue(32'hFFC0_0000, 2'd1, "R7 dir invalid write");
        issue(32'h0040_0ABC, 2'd1, "R4 leaf invalid");
        issue(32'h0040_1FFC, 2'd0, "R5 no read");
        issue(32'h0040_1FFC, 2'd1, "R7 perm write");
        drain();
        check("R7 no write-back", mem[32'h0003_0004], 32'h5555_5009);
        check("R1 leaf untouched", mem[32'h0003_0000], 32'h1234_500E);
        load_root(32'h0005_0000);
        base_model = 32'h0005_0000;
        issue(32'h4123_B538, 2'd0, "R9 new root");
        base_load = 1'b1; base_value = 32'h0001_0000;
        @(negedge clk);
        base_load = 1'b0;
        drain();
        base_model = 32'h0001_0000;
        issue(32'h4123_B538, 2'd0, "R9 reloaded root");
        issue(32'h4123_B538, 2'd1, "R1 dirty page write");
        drain();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule